// File: doc/BRIEF.md
# Virtual Register Slot Map

This block keeps a small set of virtual register slots. Each slot stands for one real register that an in-flight instruction is using. A dependency matrix built over the slots has only as many columns as there are slots, instead of one column per real register, which keeps the matrix small and its row drivers short. Each slot holds a row with one bit per real register. A mapped slot has exactly one bit set in its row, and an empty slot has no bit set.

Issue logic presents an allocate request carrying a real register number. If a valid slot already names that register, the block returns that slot and creates no second mapping. Otherwise it claims the lowest-numbered empty slot. If every slot is busy, it raises a stall in the same cycle. On completion, an instruction frees its slot by index. A separate lookup port reports, in the same cycle, whether a register is mapped and to which slot.

Top module: `vreg_map_table`

## Requirements
- R1: After reset every slot is empty: a lookup of any register reports no hit, and grant and stall are low while no request is present.
- R2: An allocate request whose register is not mapped, made while a slot is empty, raises grant in the same cycle with slot_idx equal to the lowest-numbered empty slot. From the next cycle on, that slot maps the register.
- R3: An allocate request whose register is already mapped in a valid slot raises grant and hit, returns that slot's index, and claims no further slot.
- R4: Every slot row has at most one bit set, and a slot that is not valid has an all-zero row. A lookup hits only for the registers actually allocated.
- R5: No two valid slots name the same real register.
- R6: An allocate request that misses while all slots are valid raises stall and leaves grant low in the same cycle. No mapping changes.
- R7: A free request clears the addressed slot's row and valid flag at the next clock edge. The register then misses on lookup, and the slot is again available to allocation.
- R8: A free request and an allocation that targets a different slot in the same cycle both take effect at the same clock edge. Allocation picks its slot from the occupancy before the free.
- R9: The lookup port reports lk_hit and lk_slot combinationally from the current mapping, with no effect on state.
- R10: Freeing a slot that is already empty changes no mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_req | input | 1 | Allocate request |
| alloc_reg | input | 7 | Real register number to allocate |
| free_req | input | 1 | Free request |
| free_slot | input | 3 | Slot index to free |
| lk_reg | input | 7 | Real register number to look up |
| grant | output | 1 | Allocate request served this cycle |
| hit | output | 1 | Allocate request reused an existing slot |
| stall | output | 1 | Allocate request cannot be served |
| slot_idx | output | 3 | Slot returned to the allocate request |
| lk_hit | output | 1 | Looked-up register is mapped |
| lk_slot | output | 3 | Slot holding the looked-up register |

## Verification
grant, hit, stall, slot_idx, lk_hit and lk_slot are combinational, so each is due in the cycle its request is presented. The bench drives inputs on the falling edge and samples those outputs two nanoseconds later, before the rising edge. A change of mapping from an allocation or a free becomes visible one rising edge later. The bench therefore confirms each change with a full sweep of the lookup port over all 128 registers, made after that edge with the allocate and free inputs idle. The expected mapping comes from a model in the bench that is updated at the same edge.

// File: rtl/vrt_pkg.sv
package vrt_pkg;
  localparam int DEF_NREGS  = 128;
  localparam int DEF_NSLOTS = 8;

  typedef enum logic [1:0] {
    AK_IDLE  = 2'd0,
    AK_REUSE = 2'd1,
    AK_NEW   = 2'd2,
    AK_STALL = 2'd3
  } alloc_kind_e;
endpackage

// File: rtl/vrt_slot.sv
module vrt_slot #(
  parameter int NREGS = 128,
  localparam int RW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [RW-1:0]    set_reg,
  input  logic             clr_en,
  input  logic [RW-1:0]    probe_a,
  input  logic [RW-1:0]    probe_b,
  output logic             valid,
  output logic [NREGS-1:0] row,
  output logic             match_a,
  output logic             match_b
);
  function automatic logic [NREGS-1:0] reg_to_row(input logic [RW-1:0] r);
    logic [NREGS-1:0] v;
    v = '0;
    v[r] = 1'b1;
    return v;
  endfunction

  logic [NREGS-1:0] row_q;
  logic             valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      valid_q <= 1'b0;
    end else if (set_en) begin
      row_q   <= reg_to_row(set_reg);
      valid_q <= 1'b1;
    end else if (clr_en) begin
      row_q   <= '0;
      valid_q <= 1'b0;
    end
  end

  assign valid   = valid_q;
  assign row     = row_q;
  assign match_a = valid_q & row_q[probe_a];
  assign match_b = valid_q & row_q[probe_b];
endmodule

// File: rtl/vrt_lowest.sv
module vrt_lowest #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  function automatic logic [W-1:0] first_set(input logic [N-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = W'(i);
    end
    return r;
  endfunction

  assign found = |req;
  assign idx   = first_set(req);
endmodule

// File: rtl/vrt_encode.sv
module vrt_encode #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] onehot,
  output logic         any,
  output logic [W-1:0] idx
);
  function automatic logic [W-1:0] or_index(input logic [N-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (v[i]) r = r | W'(i);
    end
    return r;
  endfunction

  assign any = |onehot;
  assign idx = or_index(onehot);
endmodule

// File: rtl/vreg_map_table.sv
module vreg_map_table
  import vrt_pkg::*;
#(
  parameter int NREGS  = DEF_NREGS,
  parameter int NSLOTS = DEF_NSLOTS,
  localparam int RW = $clog2(NREGS),
  localparam int SW = $clog2(NSLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic [RW-1:0] alloc_reg,
  input  logic          free_req,
  input  logic [SW-1:0] free_slot,
  input  logic [RW-1:0] lk_reg,
  output logic          grant,
  output logic          hit,
  output logic          stall,
  output logic [SW-1:0] slot_idx,
  output logic          lk_hit,
  output logic [SW-1:0] lk_slot
);
  logic [NSLOTS-1:0]       valid_q;
  logic [NSLOTS-1:0]       match_a;
  logic [NSLOTS-1:0]       match_b;
  logic [NSLOTS-1:0]       set_vec;
  logic [NSLOTS-1:0]       clr_vec;
  logic [NSLOTS*NREGS-1:0] rows_flat;

  logic          a_hit;
  logic [SW-1:0] a_hit_slot;
  logic          any_free;
  logic [SW-1:0] new_slot;
  logic          do_new;
  alloc_kind_e   kind;

  vrt_encode #(.N(NSLOTS)) u_enc_alloc (
    .onehot(match_a), .any(a_hit), .idx(a_hit_slot)
  );

  vrt_encode #(.N(NSLOTS)) u_enc_look (
    .onehot(match_b), .any(lk_hit), .idx(lk_slot)
  );

  vrt_lowest #(.N(NSLOTS)) u_pick (
    .req(~valid_q), .found(any_free), .idx(new_slot)
  );

  always_comb begin
    if (!alloc_req)    kind = AK_IDLE;
    else if (a_hit)    kind = AK_REUSE;
    else if (any_free) kind = AK_NEW;
    else               kind = AK_STALL;
  end

  assign do_new   = (kind == AK_NEW);
  assign grant    = (kind == AK_REUSE) || do_new;
  assign hit      = (kind == AK_REUSE);
  assign stall    = (kind == AK_STALL);
  assign slot_idx = hit ? a_hit_slot : new_slot;

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    assign set_vec[s] = do_new && (new_slot == SW'(s));
    assign clr_vec[s] = free_req && (free_slot == SW'(s));

    vrt_slot #(.NREGS(NREGS)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (set_vec[s]),
      .set_reg (alloc_reg),
      .clr_en  (clr_vec[s]),
      .probe_a (alloc_reg),
      .probe_b (lk_reg),
      .valid   (valid_q[s]),
      .row     (rows_flat[s*NREGS +: NREGS]),
      .match_a (match_a[s]),
      .match_b (match_b[s])
    );
  end
endmodule

// File: rtl/vrt_checker.sv
module vrt_checker #(
  parameter int NREGS  = 128,
  parameter int NSLOTS = 8,
  localparam int RW = $clog2(NREGS),
  localparam int SW = $clog2(NSLOTS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSLOTS-1:0]       valid_q,
  input logic [NSLOTS*NREGS-1:0] rows_flat,
  input logic                    alloc_req,
  input logic                    free_req,
  input logic [SW-1:0]           free_slot,
  input logic                    grant,
  input logic                    hit,
  input logic                    stall,
  input logic [SW-1:0]           slot_idx
);
  for (genvar s = 0; s < NSLOTS; s++) begin : g_row
    a_r4_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rows_flat[s*NREGS +: NREGS]));
    a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q[s] |-> (rows_flat[s*NREGS +: NREGS] == '0));
    for (genvar t = s + 1; t < NSLOTS; t++) begin : g_pair
      a_r5_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q[s] && valid_q[t]) |->
          (rows_flat[s*NREGS +: NREGS] != rows_flat[t*NREGS +: NREGS]));
    end
  end

  a_r6_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (alloc_req && (&valid_q) && !grant));

  a_r6_stall_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !free_req) |=> $stable(rows_flat));

  a_r2_new_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !hit) |=> valid_q[$past(slot_idx)]);

  a_r2_new_was_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !hit) |-> !valid_q[slot_idx]);

  a_r3_reuse_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && hit && !free_req) |=> $stable(valid_q));

  a_r7_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (free_req && !(grant && !hit && slot_idx == free_slot)) |=>
      !valid_q[$past(free_slot)]);
endmodule

bind vreg_map_table vrt_checker #(.NREGS(NREGS), .NSLOTS(NSLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_q   (valid_q),
  .rows_flat (rows_flat),
  .alloc_req (alloc_req),
  .free_req  (free_req),
  .free_slot (free_slot),
  .grant     (grant),
  .hit       (hit),
  .stall     (stall),
  .slot_idx  (slot_idx)
);

// File: tb/tb_vreg_map_table.sv
module tb_vreg_map_table;
  localparam int NREGS  = 128;
  localparam int NSLOTS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_req = 1'b0;
  logic [6:0] alloc_reg = '0;
  logic       free_req = 1'b0;
  logic [2:0] free_slot = '0;
  logic [6:0] lk_reg = '0;
  logic       grant, hit, stall, lk_hit;
  logic [2:0] slot_idx, lk_slot;

  int checks = 0;
  int fails  = 0;
  int mreg [NSLOTS];
  bit mval [NSLOTS];

  always #10 clk = ~clk;

  vreg_map_table #(.NREGS(NREGS), .NSLOTS(NSLOTS)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_reg(alloc_reg),
    .free_req(free_req), .free_slot(free_slot), .lk_reg(lk_reg),
    .grant(grant), .hit(hit), .stall(stall), .slot_idx(slot_idx),
    .lk_hit(lk_hit), .lk_slot(lk_slot)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int find(input int r);
    for (int s = 0; s < NSLOTS; s++) if (mval[s] && mreg[s] == r) return s;
    return -1;
  endfunction

  function automatic int lowest_free();
    for (int s = 0; s < NSLOTS; s++) if (!mval[s]) return s;
    return -1;
  endfunction

  task automatic cyc(input bit a, input int r, input bit f, input int fs, input string tag);
    int e_hit_slot, e_low;
    bit e_hit, e_stall, e_grant;
    @(negedge clk);
    alloc_req = a; alloc_reg = 7'(r); free_req = f; free_slot = 3'(fs);
    #2;
    e_hit_slot = find(r);
    e_low      = lowest_free();
    e_hit      = a && (e_hit_slot >= 0);
    e_stall    = a && !e_hit && (e_low < 0);
    e_grant    = a && !e_stall;
    check(grant == e_grant, {tag, " grant"}, grant, e_grant);
    check(stall == e_stall, {tag, " stall"}, stall, e_stall);
    check(hit == e_hit, {tag, " hit"}, hit, e_hit);
    if (e_grant)
      check(slot_idx == (e_hit ? e_hit_slot : e_low), {tag, " slot"},
            slot_idx, e_hit ? e_hit_slot : e_low);
    @(posedge clk);
    #1;
    if (f) mval[fs] = 1'b0;
    if (a && !e_hit && !e_stall) begin
      mreg[e_low] = r;
      mval[e_low] = 1'b1;
    end
    alloc_req = 1'b0; free_req = 1'b0;
  endtask

  task automatic sweep(input string tag);
    int e;
    @(negedge clk);
    for (int r = 0; r < NREGS; r++) begin
      lk_reg = 7'(r);
      #1;
      e = find(r);
      check(lk_hit == (e >= 0), {tag, " lk_hit"}, lk_hit, e >= 0);
      if (e >= 0) check(lk_slot == 3'(e), {tag, " lk_slot"}, lk_slot, e);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSLOTS; s++) begin mval[s] = 1'b0; mreg[s] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    check(grant == 1'b0, "R1 grant idle", grant, 0);
    check(stall == 1'b0, "R1 stall idle", stall, 0);
    sweep("R1 reset lookup");

    for (int k = 0; k < NSLOTS; k++) cyc(1'b1, (k * 47 + 127) % 128, 1'b0, 0, "R2 fill");
    sweep("R9 R4 R5 after fill");

    cyc(1'b1, 93, 1'b0, 0, "R3 reuse");
    sweep("R3 no new slot");

    cyc(1'b1, 7, 1'b0, 0, "R6 stall full");
    sweep("R6 unchanged");

    cyc(1'b0, 0, 1'b1, 3, "R7 free 3");
    sweep("R7 after free");
    cyc(1'b1, 7, 1'b0, 0, "R7 reuse freed slot");

    cyc(1'b0, 0, 1'b1, 1, "R7 free 1");
    cyc(1'b0, 0, 1'b1, 5, "R7 free 5");
    cyc(1'b1, 8, 1'b1, 6, "R8 free and alloc");
    sweep("R8 both applied");

    cyc(1'b0, 0, 1'b1, 5, "R10 free empty");
    sweep("R10 unchanged");

    cyc(1'b1, 0, 1'b0, 0, "R2 lowest of two");
    cyc(1'b1, 8, 1'b0, 0, "R3 reuse new");
    cyc(1'b1, 1, 1'b0, 0, "R2 last slot");
    cyc(1'b1, 2, 1'b0, 0, "R6 stall again");
    sweep("R4 R5 final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule